// File: doc/BRIEF.md
# Pipelined Embedded Memory Test Port

This block lets an external tester reach the on-chip memory arrays directly: a data SRAM, the instruction cache data array, the instruction cache tag array and a read-only array. Each access is presented on a test address bus together with write data, an array select and a read, write or tag-lookup request. It then flows through a fixed-length pipeline. A new access may be presented on every clock, so a tester can fill or dump an array at one word per cycle. Writes land in the array a fixed number of clocks after they are sampled. Reads and lookups return their word on an observation bus a fixed, longer number of clocks after they are sampled.

Before any access is accepted, an internal sequencer performs the test-mode entry handshake. When the test-mode request is raised, it drives a core reset strobe for a fixed run of cycles, then a core stall for a further fixed run, and only then declares the port ready. The same sequence is repeated every time test mode is re-entered after being dropped. In tag-lookup mode the port compares the stored tag of the indexed cache line with the upper address bits. It first raises a one-cycle hit flag, and two cycles later delivers the cache data word of that line.

Top module: `memtest_port`

## Requirements
- R1: After reset, core_rst_o, core_stall_o, tm_ready, obs_valid, tag_hit and obs_data are all zero. If tm_en is sampled high at edge E with the port idle, core_rst_o is high after edges E to E+5 (6 cycles). core_stall_o is then high after edges E+6 to E+13 (8 cycles). tm_ready is high from edge E+14 on, and at most one of the three is ever high.
- R2: tm_en sampled low returns the port to idle on the next edge, so that all three entry outputs go low. Raising tm_en again repeats the whole R1 sequence. Every access sampled while tm_ready is low is discarded: it writes nothing and returns nothing.
- R3: A write sampled at edge T is committed to its array at edge T+3, which is the fourth edge counting T. A read of the same word sampled at edge T+1 already returns the new data.
- R4: A read sampled at edge T drives obs_valid high with the word on obs_data after edge T+5, the sixth edge counting T, for exactly one cycle.
- R5: Accesses may be sampled on consecutive edges. Streams of back-to-back writes followed by back-to-back reads return every word in issue order at one word per cycle.
- R6: With wr_inhibit high at the sampling edge, a write to any array is ignored.
- R7: With cap_en low at the sampling edge, a write to any array is ignored.
- R8: The read-only array (t_sel = 3) is indexed by t_addr[5:0] with 6-bit value a. It returns {8'hC3, b, ~b, b ^ 8'h5A}, where b = {2'b00, a}. Writes to it are ignored. It uses the R4 timing.
- R9: Tag entries are written with t_sel = 2. Bit 4 of t_wdata is the valid bit, and t_wdata[3:0] is the tag. A lookup (t_lk) takes the line index from t_addr[3:0] and compares against t_addr[7:4]. It hits only if the indexed entry is valid and its stored tag equals t_addr[7:4]. On a hit, tag_hit is high for one cycle after edge T+3.
- R10: On a lookup hit, the cache data word of the indexed line appears on obs_data with obs_valid after edge T+5. On a miss, obs_valid stays low and obs_data stays zero.
- R11: In any cycle with no read result due, obs_valid is low and obs_data is zero.
- R12: The select codes are 0 for the data SRAM, 1 for the cache data array (indexed by t_addr[3:0]), 2 for the tag array and 3 for the read-only array. A tag-array read returns {27'b0, valid, tag}. When several requests are high together, the priority is write over lookup over read. A lookup ignores t_sel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tm_en | input | 1 | Test-mode request; starts the entry sequence |
| t_addr | input | 8 | Test address |
| t_wdata | input | 32 | Test write data |
| t_sel | input | 2 | Array select |
| t_rd | input | 1 | Read request |
| t_wr | input | 1 | Write request |
| t_lk | input | 1 | Tag-lookup request |
| wr_inhibit | input | 1 | Blocks all array writes when high |
| cap_en | input | 1 | Must be high for writes to be captured |
| core_rst_o | output | 1 | Core reset strobe during entry |
| core_stall_o | output | 1 | Core stall during entry |
| tm_ready | output | 1 | Entry complete; accesses accepted |
| obs_data | output | 32 | Observation bus; zero when no result |
| obs_valid | output | 1 | Read or lookup result present |
| tag_hit | output | 1 | Lookup hit flag |

## Verification
The bench builds the port with its default parameters: 32-bit words, 8-bit addresses, a 16-line cache with 4-bit tags, a 64-word read-only array, and entry runs of 6 and 8 cycles. These small sizes let the bench exercise cases that larger ones would hide. It hits and misses on a line by changing only the upper four address bits. It reads both ends of the read-only array. It also counts every cycle of the entry sequence exactly. The bench drops and re-enters test mode while issuing accesses, which exposes any access that leaks through before the port is ready.

// File: rtl/memtest_pkg.sv
package memtest_pkg;

    parameter int unsigned MT_DW   = 32;
    parameter int unsigned MT_AW   = 8;
    parameter int unsigned MT_IDXW = 4;
    parameter int unsigned MT_ROMW = 6;
    localparam int unsigned MT_TAGW = MT_AW - MT_IDXW;

    typedef enum logic [1:0] {
        ARR_SRAM   = 2'd0,
        ARR_ICDATA = 2'd1,
        ARR_ICTAG  = 2'd2,
        ARR_ROM    = 2'd3
    } arr_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2,
        OP_LK   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,
        SEQ_PULSE = 2'd1,
        SEQ_STALL = 2'd2,
        SEQ_READY = 2'd3
    } seq_e;

    typedef struct packed {
        op_e              op;
        arr_e             arr;
        logic [MT_AW-1:0] addr;
        logic [MT_DW-1:0] wdata;
    } acc_t;

    function automatic logic [MT_IDXW-1:0] line_of(logic [MT_AW-1:0] a);
        return a[MT_IDXW-1:0];
    endfunction

    function automatic logic [MT_TAGW-1:0] tag_of(logic [MT_AW-1:0] a);
        return a[MT_AW-1:MT_IDXW];
    endfunction

    function automatic logic [MT_DW-1:0] rom_word(logic [MT_ROMW-1:0] a);
        logic [7:0] b;
        b = 8'(a);
        return MT_DW'({8'hC3, b, ~b, b ^ 8'h5A});
    endfunction

endpackage

// File: rtl/mtp_entry_seq.sv
module mtp_entry_seq
    import memtest_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 6,
    parameter int unsigned STALL_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic tm_en,
    output logic core_rst_o,
    output logic core_stall_o,
    output logic ready_o
);

    localparam int unsigned CNT_MAX = (PULSE_CYC > STALL_CYC) ? PULSE_CYC : STALL_CYC;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    seq_e          st_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !tm_en) begin
            st_q  <= SEQ_OFF;
            cnt_q <= '0;
        end else begin
            case (st_q)
                SEQ_OFF: begin
                    st_q  <= SEQ_PULSE;
                    cnt_q <= '0;
                end
                SEQ_PULSE: begin
                    if (cnt_q == CW'(PULSE_CYC - 1)) begin
                        st_q  <= SEQ_STALL;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SEQ_STALL: begin
                    if (cnt_q == CW'(STALL_CYC - 1)) begin
                        st_q  <= SEQ_READY;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: st_q <= SEQ_READY;
            endcase
        end
    end

    assign core_rst_o   = (st_q == SEQ_PULSE);
    assign core_stall_o = (st_q == SEQ_STALL);
    assign ready_o      = (st_q == SEQ_READY);

endmodule

// File: rtl/mtp_delay.sv
module mtp_delay #(
    parameter int unsigned DEPTH = 3,
    parameter type         T     = logic
) (
    input  logic clk,
    input  logic rst,
    input  T     din,
    output T     dout
);

    generate
        if (DEPTH == 0) begin : g_pass
            assign dout = din;
        end else begin : g_regs
            T stage_q [DEPTH];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < int'(DEPTH); i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= din;
                    for (int i = 1; i < int'(DEPTH); i++) stage_q[i] <= stage_q[i-1];
                end
            end
            assign dout = stage_q[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/mtp_arrays.sv
module mtp_arrays
    import memtest_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  acc_t             acc,
    output logic [MT_DW-1:0] rd_q,
    output logic             hit_q
);

    localparam int unsigned SRAM_DEPTH = 1 << MT_AW;
    localparam int unsigned LINES      = 1 << MT_IDXW;

    logic [MT_DW-1:0]   sram_mem [SRAM_DEPTH];
    logic [MT_DW-1:0]   icd_mem  [LINES];
    logic [MT_TAGW-1:0] tag_mem  [LINES];
    logic [LINES-1:0]   tag_vld;

    logic [MT_IDXW-1:0] line;
    logic [MT_TAGW-1:0] want_tag;
    logic [MT_DW-1:0]   rd_mux;
    logic               lk_match;

    assign line     = line_of(acc.addr);
    assign want_tag = tag_of(acc.addr);
    assign lk_match = tag_vld[line] && (tag_mem[line] == want_tag);

    always_ff @(posedge clk) begin
        if (acc.op == OP_WR) begin
            case (acc.arr)
                ARR_SRAM:   sram_mem[acc.addr] <= acc.wdata;
                ARR_ICDATA: icd_mem[line]      <= acc.wdata;
                ARR_ICTAG:  tag_mem[line]      <= acc.wdata[MT_TAGW-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tag_vld <= '0;
        end else if (acc.op == OP_WR && acc.arr == ARR_ICTAG) begin
            tag_vld[line] <= acc.wdata[MT_TAGW];
        end
    end

    always_comb begin
        case (acc.arr)
            ARR_SRAM:   rd_mux = sram_mem[acc.addr];
            ARR_ICDATA: rd_mux = icd_mem[line];
            ARR_ICTAG:  rd_mux = MT_DW'({tag_vld[line], tag_mem[line]});
            default:    rd_mux = rom_word(acc.addr[MT_ROMW-1:0]);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            hit_q <= 1'b0;
        end else begin
            hit_q <= (acc.op == OP_LK) && lk_match;
            case (acc.op)
                OP_RD:   rd_q <= rd_mux;
                OP_LK:   rd_q <= icd_mem[line];
                default: rd_q <= '0;
            endcase
        end
    end

endmodule

// File: rtl/memtest_port.sv
module memtest_port
    import memtest_pkg::*;
#(
    parameter int unsigned PULSE_CYC = 6,
    parameter int unsigned STALL_CYC = 8,
    parameter int unsigned WR_LAT    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tm_en,
    input  logic [MT_AW-1:0] t_addr,
    input  logic [MT_DW-1:0] t_wdata,
    input  logic [1:0]       t_sel,
    input  logic             t_rd,
    input  logic             t_wr,
    input  logic             t_lk,
    input  logic             wr_inhibit,
    input  logic             cap_en,
    output logic             core_rst_o,
    output logic             core_stall_o,
    output logic             tm_ready,
    output logic [MT_DW-1:0] obs_data,
    output logic             obs_valid,
    output logic             tag_hit
);

    localparam int unsigned PRE_STAGES = WR_LAT - 1;

    acc_t             issue;
    acc_t             at_array;
    op_e              op_s4_q;
    logic [MT_DW-1:0] arr_rd;
    logic             arr_hit;
    logic             s5_vld_q;
    logic [MT_DW-1:0] s5_dat_q;
    logic             ready;

    mtp_entry_seq #(
        .PULSE_CYC (PULSE_CYC),
        .STALL_CYC (STALL_CYC)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .tm_en        (tm_en),
        .core_rst_o   (core_rst_o),
        .core_stall_o (core_stall_o),
        .ready_o      (ready)
    );

    assign tm_ready = ready;

    always_comb begin
        issue.arr   = arr_e'(t_sel);
        issue.addr  = t_addr;
        issue.wdata = t_wdata;
        issue.op    = OP_NONE;
        if (ready) begin
            if (t_wr) begin
                if (!wr_inhibit && cap_en && arr_e'(t_sel) != ARR_ROM) issue.op = OP_WR;
            end else if (t_lk) begin
                issue.op = OP_LK;
            end else if (t_rd) begin
                issue.op = OP_RD;
            end
        end
    end

    mtp_delay #(
        .DEPTH (PRE_STAGES),
        .T     (acc_t)
    ) u_pipe (
        .clk  (clk),
        .rst  (rst),
        .din  (issue),
        .dout (at_array)
    );

    mtp_arrays u_arr (
        .clk   (clk),
        .rst   (rst),
        .acc   (at_array),
        .rd_q  (arr_rd),
        .hit_q (arr_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_s4_q   <= OP_NONE;
            s5_vld_q  <= 1'b0;
            s5_dat_q  <= '0;
            obs_valid <= 1'b0;
            obs_data  <= '0;
        end else begin
            op_s4_q   <= at_array.op;
            s5_vld_q  <= (op_s4_q == OP_RD) || (op_s4_q == OP_LK && arr_hit);
            s5_dat_q  <= arr_rd;
            obs_valid <= s5_vld_q;
            obs_data  <= s5_vld_q ? s5_dat_q : '0;
        end
    end

    assign tag_hit = arr_hit;

endmodule

// File: rtl/memtest_port_chk.sv
module memtest_port_chk
    import memtest_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tm_en,
    input logic             t_rd,
    input logic             t_wr,
    input logic             t_lk,
    input logic             core_rst_o,
    input logic             core_stall_o,
    input logic             tm_ready,
    input logic [MT_DW-1:0] obs_data,
    input logic             obs_valid,
    input logic             tag_hit
);

    assert_phase_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({core_rst_o, core_stall_o, tm_ready}));

    assert_stall_follows_pulse_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(core_stall_o) |-> $past(core_rst_o));

    assert_ready_follows_stall_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(tm_ready) |-> $past(core_stall_o));

    assert_drop_to_idle_R2: assert property (@(posedge clk) disable iff (rst)
        !tm_en |=> (!tm_ready && !core_rst_o && !core_stall_o));

    assert_read_latency_R4: assert property (@(posedge clk) disable iff (rst)
        obs_valid |-> $past(tm_ready && !t_wr && (t_rd || t_lk), 6));

    assert_hit_latency_R9: assert property (@(posedge clk) disable iff (rst)
        tag_hit |-> $past(tm_ready && !t_wr && t_lk, 4));

    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !obs_valid |-> (obs_data == '0));

endmodule

bind memtest_port memtest_port_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .tm_en        (tm_en),
    .t_rd         (t_rd),
    .t_wr         (t_wr),
    .t_lk         (t_lk),
    .core_rst_o   (core_rst_o),
    .core_stall_o (core_stall_o),
    .tm_ready     (tm_ready),
    .obs_data     (obs_data),
    .obs_valid    (obs_valid),
    .tag_hit      (tag_hit)
);

// File: tb/memtest_port_test.sv
`timescale 1ns/1ps
module memtest_port_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tm_en = 1'b0;
    logic [7:0]  t_addr = '0;
    logic [31:0] t_wdata = '0;
    logic [1:0]  t_sel = '0;
    logic        t_rd = 1'b0, t_wr = 1'b0, t_lk = 1'b0;
    logic        wr_inhibit = 1'b0, cap_en = 1'b1;
    logic        core_rst_o, core_stall_o, tm_ready, obs_valid, tag_hit;
    logic [31:0] obs_data;

    always #2.5 clk = ~clk;

    memtest_port uut (
        .clk(clk), .rst(rst), .tm_en(tm_en), .t_addr(t_addr), .t_wdata(t_wdata),
        .t_sel(t_sel), .t_rd(t_rd), .t_wr(t_wr), .t_lk(t_lk),
        .wr_inhibit(wr_inhibit), .cap_en(cap_en),
        .core_rst_o(core_rst_o), .core_stall_o(core_stall_o), .tm_ready(tm_ready),
        .obs_data(obs_data), .obs_valid(obs_valid), .tag_hit(tag_hit)
    );

    typedef struct {
        int          due;
        logic [31:0] data;
        string       req;
    } exp_t;

    exp_t        rq[$];
    int          hq[$];
    int          edge_n = 0;
    int          checks = 0;
    int          failures = 0;
    bit          mdl_ready = 0;
    bit          mon_on = 0;

    logic [31:0] m_sram [256];
    logic [31:0] m_icd  [16];
    logic [3:0]  m_tt   [16];
    bit          m_tv   [16];

    always @(posedge clk) edge_n <= edge_n + 1;

    function automatic void check(bit ok, string req, logic [32:0] act, logic [32:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at edge %0d", req, act, exp, edge_n);
        end
    endfunction

    function automatic logic [31:0] rom_exp(logic [5:0] a);
        logic [7:0] b;
        b = {2'b00, a};
        return {8'hC3, b, ~b, b ^ 8'h5A};
    endfunction

    function automatic logic [31:0] model_read(logic [1:0] sel, logic [7:0] a);
        case (sel)
            2'd0:    return m_sram[a];
            2'd1:    return m_icd[a[3:0]];
            2'd2:    return {27'b0, m_tv[a[3:0]], m_tt[a[3:0]]};
            default: return rom_exp(a[5:0]);
        endcase
    endfunction

    // Monitor: pops expected results as they fall due
    always @(negedge clk) begin
        if (mon_on) begin
            if (rq.size() > 0 && rq[0].due == edge_n) begin
                exp_t e;
                e = rq.pop_front();
                check(obs_valid === 1'b1 && obs_data === e.data, e.req,
                      {obs_valid, obs_data}, {1'b1, e.data});
            end else begin
                check(obs_valid === 1'b0 && obs_data === 32'h0, "R11",
                      {obs_valid, obs_data}, 33'h0);
            end
            if (hq.size() > 0 && hq[0] == edge_n) begin
                void'(hq.pop_front());
                check(tag_hit === 1'b1, "R9", {32'h0, tag_hit}, 33'h1);
            end else begin
                check(tag_hit === 1'b0, "R9", {32'h0, tag_hit}, 33'h0);
            end
        end
    end

    task automatic drive(bit wr, bit rd, bit lk, logic [1:0] sel, logic [7:0] a,
                         logic [31:0] d, bit inh, bit cap);
        @(negedge clk);
        t_wr = wr; t_rd = rd; t_lk = lk; t_sel = sel; t_addr = a; t_wdata = d;
        wr_inhibit = inh; cap_en = cap;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 2'd0, 8'h0, 32'h0, 0, 1);
    endtask

    task automatic do_wr(logic [1:0] sel, logic [7:0] a, logic [31:0] d, bit inh, bit cap, bit also_rd);
        drive(1, also_rd, 0, sel, a, d, inh, cap);
        if (mdl_ready && !inh && cap) begin
            case (sel)
                2'd0: m_sram[a] = d;
                2'd1: m_icd[a[3:0]] = d;
                2'd2: begin m_tt[a[3:0]] = d[3:0]; m_tv[a[3:0]] = d[4]; end
                default: ;
            endcase
        end
    endtask

    task automatic do_rd(logic [1:0] sel, logic [7:0] a, string req);
        drive(0, 1, 0, sel, a, 32'h0, 0, 1);
        if (mdl_ready) rq.push_back('{edge_n + 6, model_read(sel, a), req});
    endtask

    task automatic do_lk(logic [7:0] a, bit also_rd, string req);
        drive(0, also_rd, 1, 2'd0, a, 32'h0, 0, 1);
        if (mdl_ready && m_tv[a[3:0]] && m_tt[a[3:0]] == a[7:4]) begin
            hq.push_back(edge_n + 4);
            rq.push_back('{edge_n + 6, m_icd[a[3:0]], req});
        end
    endtask

    // Entry sequence; optionally pokes accesses while not ready
    task automatic enter(bit poke);
        int rc = 0, sc = 0, first_rdy = 0;
        @(negedge clk);
        tm_en = 1'b1;
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            rc += int'(core_rst_o);
            sc += int'(core_stall_o);
            if (tm_ready && first_rdy == 0) first_rdy = k;
            if (poke && k <= 10) begin
                t_sel = 2'd0; t_addr = 8'h05; t_wdata = 32'hBAD0_0000 + k;
                t_wr = k[0]; t_rd = !k[0]; t_lk = 1'b0;
            end else begin
                t_wr = 1'b0; t_rd = 1'b0; t_lk = 1'b0;
            end
        end
        check(rc == 6, "R1", 33'(rc), 33'd6);
        check(sc == 8, "R1", 33'(sc), 33'd8);
        check(first_rdy == 15, "R1", 33'(first_rdy), 33'd15);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_tv[i] = 0;
        repeat (3) @(negedge clk);
        check({core_rst_o, core_stall_o, tm_ready, obs_valid, tag_hit} === 5'b0 && obs_data === 32'h0,
              "R1", {28'h0, core_rst_o, core_stall_o, tm_ready, obs_valid, tag_hit}, 33'h0);
        rst = 1'b0;
        @(negedge clk);
        mon_on = 1;
        enter(0);
        mdl_ready = 1;

        do_wr(2'd0, 8'h05, 32'hA5A5_0005, 0, 1, 0);
        // R5: back-to-back streams
        for (int i = 0; i < 16; i++) do_wr(2'd0, 8'h40 + 8'(i), 32'h1000_0000 + 32'(i) * 32'h0101, 0, 1, 0);
        for (int i = 0; i < 16; i++) do_rd(2'd0, 8'h40 + 8'(i), "R5");
        // R3: read right after write
        do_wr(2'd0, 8'h80, 32'hC0DE_0080, 0, 1, 0);
        do_rd(2'd0, 8'h80, "R3");
        // R4: isolated read, idle checks around it pin the cycle
        idle(8);
        do_rd(2'd0, 8'h05, "R4");
        idle(8);
        // R6 / R7
        do_wr(2'd0, 8'h80, 32'hDEAD_DEAD, 1, 1, 0);
        do_rd(2'd0, 8'h80, "R6");
        do_wr(2'd0, 8'h80, 32'hBEEF_BEEF, 0, 0, 0);
        do_rd(2'd0, 8'h80, "R7");
        // R8: read-only array
        do_rd(2'd3, 8'h00, "R8");
        do_rd(2'd3, 8'h01, "R8");
        do_rd(2'd3, 8'h2A, "R8");
        do_rd(2'd3, 8'h3F, "R8");
        do_wr(2'd3, 8'h2A, 32'hFFFF_FFFF, 0, 1, 0);
        do_rd(2'd3, 8'h2A, "R8");
        // R9 / R10: tag and cache data
        do_wr(2'd1, 8'h03, 32'h1CAC_0003, 0, 1, 0);
        do_wr(2'd1, 8'h03, 32'h0BAD_0BAD, 1, 1, 0);
        do_wr(2'd2, 8'h03, 32'h0000_001A, 0, 1, 0);
        do_wr(2'd2, 8'h04, 32'h0000_000A, 0, 1, 0);
        do_wr(2'd1, 8'h04, 32'h1CAC_0004, 0, 1, 0);
        do_lk(8'hA3, 0, "R10");
        do_lk(8'hB3, 0, "R10");
        do_lk(8'hA4, 0, "R10");
        do_lk(8'hA3, 0, "R10");
        // R12: encodings and priority
        do_rd(2'd2, 8'h03, "R12");
        do_rd(2'd2, 8'h04, "R12");
        do_rd(2'd1, 8'h03, "R12");
        do_wr(2'd0, 8'h90, 32'h9090_9090, 0, 1, 1);
        do_rd(2'd0, 8'h90, "R12");
        do_lk(8'hA3, 1, "R12");
        idle(10);
        // R2: drop and re-enter while poking accesses
        @(negedge clk);
        tm_en = 1'b0;
        mdl_ready = 0;
        repeat (2) @(negedge clk);
        check({tm_ready, core_rst_o, core_stall_o} === 3'b0, "R2",
              {30'h0, tm_ready, core_rst_o, core_stall_o}, 33'h0);
        enter(1);
        mdl_ready = 1;
        do_rd(2'd0, 8'h05, "R2");
        idle(12);
        check(rq.size() == 0 && hq.size() == 0, "R4", 33'(rq.size() + hq.size()), 33'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired at edge %0d", edge_n);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule